// File: doc/BRIEF.md
# Motion-Search Instruction Processor

A compact register-register processor that runs block-matching motion-search programs. Every instruction is one 16-bit word, and only eight operations exist. They cover control flow, register moves, byte constants, add and subtract, halving, a row-wide sum of absolute differences (SAD) and a request to fill a scratchpad from external memory. Thirty-two 16-bit registers are provided. Registers r0..r23 are general purpose. Registers r24..r31 have fixed roles. r24 points at the current-block row and r25 points at the candidate row. r26 holds the candidate row stride. r31 drives the `spr_out` port, so a search program can publish its result there.

Instructions come from an asynchronous-read program memory that is addressed by `imem_addr`. Pixels come from two asynchronous-read 8-bit scratchpads: one for the current block and one for the search area. The SAD operation is serial. It handles one pixel pair per cycle and holds the program counter for 16 cycles. After the row it adds the row total to a register, then moves both row pointers forward. A scratchpad fill is a level request that is held until the external stub answers with a done pulse.

Top module: `me_asip_core`

## Requirements
- R1: While `rst_n` is low, the program counter (`imem_addr`) is 0, every register is 0 (so `spr_out` = 0), `ld_req` is 0, and both flags are clear.
- R2: The opcode is bits [15:13]: 0 jump, 1 move, 2 byte constant, 3 add, 4 subtract, 5 halve, 6 SAD, 7 fill. For a jump, bits [12:11] are the condition: 00 always, 01 when the negative flag is clear, 10 when it is set, 11 when the zero flag is set. When taken, the jump loads the PC with the absolute target in bits [7:0]. Otherwise the PC advances by one.
- R3: For the register forms, rd is bits [9:5] and rs is bits [4:0]. A move copies rs into rd. Register r31 is driven onto `spr_out`.
- R4: For a byte constant, bit 12 selects the byte (1 upper, 0 lower) and bits [11:8] name register 16+n. The 8-bit immediate in bits [7:0] replaces only that byte, and the other byte keeps its value.
- R5: Add writes rd+rs and subtract writes rd-rs into rd, both modulo 2^16. Each sets the zero flag when the result is 0 and sets the negative flag to result bit 15.
- R6: Halve writes rs shifted right arithmetically by one into rd, and sets the flags the same way as R5.
- R7: SAD adds to rd the sum over i=0..15 of |cur[r24+i] - srch[r25+i]|, with scratchpad addresses taken modulo 256. It sets the zero flag from the new rd and clears the negative flag.
- R8: When SAD completes, r24 grows by 16 and r25 grows by r26.
- R9: A SAD holds `imem_addr` for exactly 16 cycles, then advances it by one.
- R10: A fill (bit 12 = scratchpad select, rs = address register) raises `ld_req` with `ld_sel` and `ld_addr` = rs. It keeps the request and the PC unchanged until the cycle in which `ld_done` is high, then the PC advances.
- R11: Move, byte constant, fill and jump leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Program counter, address of the program memory |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| cur_raddr | output | 8 | Current-block scratchpad read address |
| cur_rdata | input | 8 | Current-block pixel |
| srch_raddr | output | 8 | Search-area scratchpad read address |
| srch_rdata | input | 8 | Search-area pixel |
| ld_req | output | 1 | Scratchpad fill request, held until done |
| ld_sel | output | 1 | Fill target: 0 current block, 1 search area |
| ld_addr | output | 16 | External address for the fill |
| ld_done | input | 1 | Fill completion pulse from the stub |
| spr_out | output | 16 | Contents of r31 |

## Verification
The bench targets subtract wrap-around at 0x8000-1, halving of a negative value, and an add that lands exactly on zero. A design with a logical shift would return 0x7FFC instead of 0xFFFC. A design with a broken zero flag would take the wrong branch. For SAD, the bench sets the negative flag just before the row operation and then branches on it. A design that leaves the flag alone would branch when it should not. An all-equal row with a zero accumulator must take the zero branch. The bench counts the cycles for which the PC is held on each SAD, so a design that is off by one cycle shows a count other than 16. It also reads back both row pointers after two SADs, which catches a missing or doubled advance. The fill test uses a stub with a three-cycle latency and a negative flag set before the fill. A design that drops the request early, moves the PC, or lets the fill disturb the flags shows up in the request length or in the branch target.

// File: rtl/me_asip_pkg.sv
package me_asip_pkg;

    typedef enum logic [2:0] {
        OP_JMP  = 3'd0,
        OP_MOV  = 3'd1,
        OP_LDI  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_DIV2 = 3'd5,
        OP_SAD  = 3'd6,
        OP_LD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SAD  = 2'd1,
        ST_LOAD = 2'd2
    } st_e;

    // Jump condition codes
    localparam logic [1:0] CND_ALWAYS = 2'd0;
    localparam logic [1:0] CND_NCLR   = 2'd1;
    localparam logic [1:0] CND_NSET   = 2'd2;
    localparam logic [1:0] CND_ZSET   = 2'd3;

    typedef struct packed {
        op_e        op;
        logic [1:0] cond;
        logic [4:0] rd;
        logic [4:0] rs;
        logic       byte_hi;
        logic [3:0] ldi_rd;
        logic [7:0] imm;
        logic [7:0] target;
        logic       mem_sel;
    } dec_s;

endpackage

// File: rtl/me_asip_decode.sv
module me_asip_decode
    import me_asip_pkg::*;
(
    input  logic [15:0] instr,
    output dec_s        dec
);
    always_comb begin
        dec.op      = op_e'(instr[15:13]);
        dec.cond    = instr[12:11];
        dec.byte_hi = instr[12];
        dec.mem_sel = instr[12];
        dec.ldi_rd  = instr[11:8];
        dec.imm     = instr[7:0];
        dec.target  = instr[7:0];
        dec.rd      = instr[9:5];
        dec.rs      = instr[4:0];
    end
endmodule

// File: rtl/me_asip_absdiff.sv
module me_asip_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [PIX_W-1:0] diff
);
    always_comb begin
        if (a >= b) diff = a - b;
        else        diff = b - a;
    end
endmodule

// File: rtl/me_asip_regfile.sv
module me_asip_regfile #(
    parameter int DATA_W  = 16,
    parameter int NREG    = 32,
    parameter int GPR_N   = 24,
    parameter int ROW_PIX = 16,
    localparam int AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] cur_ptr,
    output logic [DATA_W-1:0] cand_ptr,
    output logic [DATA_W-1:0] out_reg
);
    localparam int CUR_IDX    = GPR_N;
    localparam int CAND_IDX   = GPR_N + 1;
    localparam int STRIDE_IDX = GPR_N + 2;
    localparam int OUT_IDX    = NREG - 1;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (adv) begin
            regs_d[CUR_IDX]  = regs_q[CUR_IDX] + DATA_W'(ROW_PIX);
            regs_d[CAND_IDX] = regs_q[CAND_IDX] + regs_q[STRIDE_IDX];
        end
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_a  = regs_q[raddr_a];
    assign rdata_b  = regs_q[raddr_b];
    assign cur_ptr  = regs_q[CUR_IDX];
    assign cand_ptr = regs_q[CAND_IDX];
    assign out_reg  = regs_q[OUT_IDX];
endmodule

// File: rtl/me_asip_core.sv
module me_asip_core
    import me_asip_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PC_W    = 8,
    parameter int SP_AW   = 8,
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [15:0]       imem_data,
    output logic [SP_AW-1:0]  cur_raddr,
    input  logic [PIX_W-1:0]  cur_rdata,
    output logic [SP_AW-1:0]  srch_raddr,
    input  logic [PIX_W-1:0]  srch_rdata,
    output logic              ld_req,
    output logic              ld_sel,
    output logic [DATA_W-1:0] ld_addr,
    input  logic              ld_done,
    output logic [DATA_W-1:0] spr_out
);
    localparam int CNT_W = $clog2(ROW_PIX);
    localparam int RA_W  = 5;

    typedef struct packed {
        st_e               st;
        logic [PC_W-1:0]   pc;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        logic              zf;
        logic              nf;
    } core_s;

    core_s s_q, s_d;
    dec_s  dec;

    logic              rf_we;
    logic [RA_W-1:0]   rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic              rf_adv;
    logic [RA_W-1:0]   rf_raddr_a;
    logic [DATA_W-1:0] ra_val, rb_val;
    logic [DATA_W-1:0] cur_ptr, cand_ptr;
    logic [DATA_W-1:0] cur_full, cand_full;
    logic [PIX_W-1:0]  pix_diff;
    logic [DATA_W-1:0] row_sum;
    logic [DATA_W-1:0] alu_res;
    logic              jmp_taken;
    logic              req_c;
    logic              sad_busy;

    me_asip_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    me_asip_regfile #(
        .DATA_W  (DATA_W),
        .NREG    (32),
        .GPR_N   (24),
        .ROW_PIX (ROW_PIX)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .adv      (rf_adv),
        .raddr_a  (rf_raddr_a),
        .raddr_b  (dec.rs),
        .rdata_a  (ra_val),
        .rdata_b  (rb_val),
        .cur_ptr  (cur_ptr),
        .cand_ptr (cand_ptr),
        .out_reg  (spr_out)
    );

    me_asip_absdiff #(.PIX_W(PIX_W)) u_ad (
        .a    (cur_rdata),
        .b    (srch_rdata),
        .diff (pix_diff)
    );

    // Pixel addressing follows the in-row counter
    assign cur_full   = cur_ptr + DATA_W'(s_q.cnt);
    assign cand_full  = cand_ptr + DATA_W'(s_q.cnt);
    assign cur_raddr  = cur_full[SP_AW-1:0];
    assign srch_raddr = cand_full[SP_AW-1:0];
    assign row_sum    = s_q.acc + DATA_W'(pix_diff);

    // Byte-constant targets live in the upper half of the file
    assign rf_raddr_a = (dec.op == OP_LDI) ? {1'b1, dec.ldi_rd} : dec.rd;

    always_comb begin
        unique case (dec.cond)
            CND_ALWAYS: jmp_taken = 1'b1;
            CND_NCLR:   jmp_taken = !s_q.nf;
            CND_NSET:   jmp_taken = s_q.nf;
            default:    jmp_taken = s_q.zf;
        endcase
    end

    always_comb begin
        unique case (dec.op)
            OP_ADD:  alu_res = ra_val + rb_val;
            OP_SUB:  alu_res = ra_val - rb_val;
            default: alu_res = {rb_val[DATA_W-1], rb_val[DATA_W-1:1]};
        endcase
    end

    always_comb begin
        s_d      = s_q;
        rf_we    = 1'b0;
        rf_waddr = dec.rd;
        rf_wdata = '0;
        rf_adv   = 1'b0;
        req_c    = 1'b0;
        unique case (s_q.st)
            ST_RUN: begin
                unique case (dec.op)
                    OP_JMP: begin
                        s_d.pc = jmp_taken ? PC_W'(dec.target) : s_q.pc + 1'b1;
                    end
                    OP_MOV: begin
                        rf_we    = 1'b1;
                        rf_wdata = rb_val;
                        s_d.pc   = s_q.pc + 1'b1;
                    end
                    OP_LDI: begin
                        rf_we    = 1'b1;
                        rf_waddr = {1'b1, dec.ldi_rd};
                        rf_wdata = dec.byte_hi ? {dec.imm, ra_val[7:0]}
                                               : {ra_val[DATA_W-1:8], dec.imm};
                        s_d.pc   = s_q.pc + 1'b1;
                    end
                    OP_ADD, OP_SUB, OP_DIV2: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_res;
                        s_d.zf   = (alu_res == '0);
                        s_d.nf   = alu_res[DATA_W-1];
                        s_d.pc   = s_q.pc + 1'b1;
                    end
                    OP_SAD: begin
                        s_d.acc = DATA_W'(pix_diff);
                        s_d.cnt = CNT_W'(1);
                        s_d.st  = ST_SAD;
                    end
                    default: begin
                        req_c = 1'b1;
                        if (ld_done) s_d.pc = s_q.pc + 1'b1;
                        else         s_d.st = ST_LOAD;
                    end
                endcase
            end
            ST_SAD: begin
                if (s_q.cnt == CNT_W'(ROW_PIX - 1)) begin
                    rf_we    = 1'b1;
                    rf_wdata = ra_val + row_sum;
                    rf_adv   = 1'b1;
                    s_d.zf   = ((ra_val + row_sum) == '0);
                    s_d.nf   = 1'b0;
                    s_d.acc  = '0;
                    s_d.cnt  = '0;
                    s_d.st   = ST_RUN;
                    s_d.pc   = s_q.pc + 1'b1;
                end else begin
                    s_d.acc = row_sum;
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                req_c = 1'b1;
                if (ld_done) begin
                    s_d.st = ST_RUN;
                    s_d.pc = s_q.pc + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_RUN;
            s_q.pc  <= '0;
            s_q.cnt <= '0;
            s_q.acc <= '0;
            s_q.zf  <= 1'b0;
            s_q.nf  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr = s_q.pc;
    assign ld_req    = req_c;
    assign ld_sel    = dec.mem_sel;
    assign ld_addr   = rb_val;
    assign sad_busy  = (s_q.st == ST_SAD);
endmodule

// File: rtl/me_asip_chk.sv
module me_asip_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic [15:0]     imem_data,
    input logic            ld_req,
    input logic            ld_done,
    input logic            sad_busy
);
    // R1: reset forces the program counter to zero
    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0));

    // R2: unconditional jump lands on its absolute target
    a_r2_jump_always: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[15:11] == 5'b00000) |=> (imem_addr == $past(imem_data[PC_W-1:0])));

    // R9: fetch is frozen while a row SAD is in progress
    a_r9_sad_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sad_busy |-> $stable(imem_addr));

    // R9: leaving the SAD moves to the next instruction
    a_r9_sad_exit_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sad_busy) |-> (imem_addr == $past(imem_addr) + 1'b1));

    // R10: an unanswered fill request persists
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_done) |=> ld_req);

    // R10: an unanswered fill request freezes fetch
    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_done) |=> $stable(imem_addr));
endmodule

bind me_asip_core me_asip_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .ld_req    (ld_req),
    .ld_done   (ld_done),
    .sad_busy  (sad_busy)
);

// File: tb/me_asip_core_bench.sv
`timescale 1ns/1ps
module me_asip_core_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic [7:0]  cur_raddr, srch_raddr;
    logic [7:0]  cur_rdata, srch_rdata;
    logic        ld_req, ld_sel, ld_done;
    logic [15:0] ld_addr, spr_out;

    logic [15:0] prog     [256];
    logic [7:0]  cur_mem  [256];
    logic [7:0]  srch_mem [256];

    int checks = 0;
    int errors = 0;
    int fill   = 0;
    int sad_pc_a = -1, sad_pc_b = -1;
    int sad_cyc_a, sad_cyc_b, req_cyc;
    int ld_wait;
    logic [15:0] seen_addr;
    logic        seen_sel;

    always #2.5 clk = ~clk;

    assign imem_data  = prog[imem_addr];
    assign cur_rdata  = cur_mem[cur_raddr];
    assign srch_rdata = srch_mem[srch_raddr];

    me_asip_core u_me_asip_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .cur_raddr(cur_raddr), .cur_rdata(cur_rdata),
        .srch_raddr(srch_raddr), .srch_rdata(srch_rdata),
        .ld_req(ld_req), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_done(ld_done), .spr_out(spr_out)
    );

    // External fetch stub: answers a request after LAT waiting cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            ld_done <= 1'b0;
            ld_wait <= 0;
        end else if (ld_req && !ld_done) begin
            ld_done <= (ld_wait == LAT - 1);
            ld_wait <= ld_wait + 1;
            seen_addr <= ld_addr;
            seen_sel  <= ld_sel;
        end else begin
            ld_done <= 1'b0;
            ld_wait <= 0;
        end
    end

    // Encoders
    function automatic logic [15:0] f_j(input int c, input int t);
        return {3'd0, 2'(c), 3'd0, 8'(t)};
    endfunction
    function automatic logic [15:0] f_rr(input int op, input int rd, input int rs);
        return {3'(op), 3'd0, 5'(rd), 5'(rs)};
    endfunction
    function automatic logic [15:0] f_ldi(input int hi, input int rd4, input int imm);
        return {3'd2, 1'(hi), 4'(rd4), 8'(imm)};
    endfunction
    function automatic logic [15:0] f_ld(input int sel, input int rs);
        return {3'd7, 1'(sel), 7'd0, 5'(rs)};
    endfunction

    function automatic logic [15:0] ref_alu(input int op, input logic [15:0] a, input logic [15:0] b);
        if (op == 3) return a + b;
        if (op == 4) return a - b;
        return {b[15], b[15:1]};
    endfunction

    function automatic int ref_sad(input int cb, input int sb);
        int s = 0;
        for (int i = 0; i < 16; i++) begin
            int d = int'(cur_mem[(cb + i) & 255]) - int'(srch_mem[(sb + i) & 255]);
            s += (d < 0) ? -d : d;
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = f_j(0, i);
        fill = 0;
    endtask
    task automatic emit(input logic [15:0] w);
        prog[fill] = w;
        fill++;
    endtask
    task automatic load16(input int rd4, input logic [15:0] v);
        emit(f_ldi(0, rd4, v[7:0]));
        emit(f_ldi(1, rd4, v[15:8]));
    endtask

    task automatic run_prog(input int ha, input int hb, output int where);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sad_cyc_a = 0; sad_cyc_b = 0; req_cyc = 0;
        where = -1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (int'(imem_addr) == sad_pc_a) sad_cyc_a++;
            if (int'(imem_addr) == sad_pc_b) sad_cyc_b++;
            if (ld_req) req_cyc++;
            if (int'(imem_addr) == ha || int'(imem_addr) == hb) begin
                where = int'(imem_addr);
                break;
            end
        end
        if (where < 0) begin
            errors++; checks++;
            $display("FAIL run: program did not halt, actual pc %0h expected %0h", imem_addr, hb);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int where;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) begin
            cur_mem[i]  = 8'($urandom());
            srch_mem[i] = 8'($urandom());
        end

        // R1: reset state
        clear_prog();
        emit(f_rr(1, 31, 31));
        repeat (3) @(negedge clk);
        chk("R1 pc", imem_addr, 0);
        chk("R1 spr_out", spr_out, 0);
        chk("R1 ld_req", ld_req, 0);

        // R4: byte constants keep the other byte
        clear_prog();
        emit(f_ldi(0, 15, 8'h34));
        emit(f_ldi(1, 15, 8'h12));
        emit(f_ldi(1, 15, 8'hAB));
        emit(f_j(0, 3));
        run_prog(3, 3, where);
        chk("R4 byte merge", spr_out, 16'hAB34);

        // R3: move chain into the output register
        clear_prog();
        load16(0, 16'hC35A);
        emit(f_rr(1, 3, 16));
        emit(f_rr(1, 31, 3));
        emit(f_j(0, 4));
        run_prog(4, 4, where);
        chk("R3 move", spr_out, 16'hC35A);

        // R5 R6 R2 R11: arithmetic with branch on flags
        for (int t = 0; t < 24; t++) begin
            logic [15:0] a, b, res;
            int op, cnd, taken;
            a = 16'($urandom()); b = 16'($urandom());
            op = 3 + int'($urandom_range(0, 2));
            cnd = int'($urandom_range(0, 3));
            if (t == 0) begin a = 16'h8000; b = 16'h0001; op = 4; cnd = 1; end
            if (t == 1) begin b = 16'hFFF9; op = 5; cnd = 2; end
            if (t == 2) begin a = 16'hFFFF; b = 16'h0001; op = 3; cnd = 3; end
            if (t == 3) begin a = 16'h0005; b = 16'h0009; op = 4; cnd = 3; end
            res = ref_alu(op, a, b);
            case (cnd)
                0: taken = 1;
                1: taken = !res[15];
                2: taken = res[15];
                default: taken = (res == 16'h0);
            endcase
            clear_prog();
            load16(0, a);
            load16(1, b);
            emit(f_rr(1, 0, 16));
            emit(f_rr(op, 0, 17));
            emit(f_rr(1, 31, 0));
            emit(f_j(cnd, 10));
            run_prog(10, 8, where);
            chk((op == 5) ? "R6 halve result" : "R5 add/sub result", spr_out, res);
            chk("R2 R11 branch on flags", where, taken ? 10 : 8);
        end

        // R7 R8 R9: two row SADs, then read back rd or a pointer
        for (int t = 0; t < 4; t++) begin
            int c0, s0, st, x, cnd, pick;
            logic [15:0] exp_v;
            c0 = int'($urandom_range(0, 200));
            s0 = int'($urandom_range(0, 200));
            st = int'($urandom_range(1, 40));
            x  = int'($urandom_range(0, 4000));
            cnd = 2;
            pick = (t == 1) ? 24 : (t == 2) ? 25 : 0;
            if (t == 3) begin
                x = 0; cnd = 3; st = 16;
                for (int i = 0; i < 32; i++) srch_mem[(s0 + i) & 255] = cur_mem[(c0 + i) & 255];
            end
            if (pick == 24)      exp_v = 16'(c0 + 32);
            else if (pick == 25) exp_v = 16'(s0 + 2 * st);
            else                 exp_v = 16'(x + ref_sad(c0, s0) + ref_sad(c0 + 16, s0 + st));
            clear_prog();
            load16(8, 16'(c0));
            load16(9, 16'(s0));
            load16(10, 16'(st));
            load16(0, 16'(x));
            emit(f_rr(1, 0, 16));
            emit(f_ldi(0, 1, 1));
            emit(f_rr(4, 2, 17));
            emit(f_rr(6, 0, 0));
            emit(f_rr(6, 0, 0));
            emit(f_rr(1, 31, pick));
            emit(f_j(cnd, 16));
            sad_pc_a = 11; sad_pc_b = 12;
            run_prog(16, 15, where);
            sad_pc_a = -1; sad_pc_b = -1;
            if (pick == 0) chk("R7 sad accumulate", spr_out, exp_v);
            else           chk("R8 pointer advance", spr_out, exp_v);
            chk("R9 first sad hold cycles", sad_cyc_a, 16);
            chk("R9 second sad hold cycles", sad_cyc_b, 16);
            chk("R7 sad flags branch", where, (t == 3) ? 16 : 15);
        end

        // R10 R11: fill handshake, flags survive the fill
        clear_prog();
        load16(0, 16'h2B7C);
        emit(f_ldi(0, 1, 1));
        emit(f_rr(4, 2, 17));
        emit(f_ld(1, 16));
        emit(f_rr(1, 31, 16));
        emit(f_j(2, 8));
        run_prog(8, 7, where);
        chk("R10 request length", req_cyc, LAT + 1);
        chk("R10 fill address", seen_addr, 16'h2B7C);
        chk("R10 fill select", seen_sel, 1);
        chk("R10 continues after done", spr_out, 16'h2B7C);
        chk("R11 flags kept over fill", where, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule